// File: doc/BRIEF.md
# Compositor Register Readout Port

This block is a second way out of a display compositor for the composed pixel stream. When the register-output control bit is set, pixels from the compositor go into a small internal FIFO. A CPU or DMA engine polls them from one readout register instead of the display FIFO. The reader sets the pace. A write with bit 31 set begins a frame. A write with bit 30 set releases the next line once the current line has been read.

Each read returns one word, registered and valid in the cycle after the read strobe. In the normal layout the word holds one 24-bit RGB pixel plus three status flags. In packed mode it holds two RGB565 pixels and no status at all. A one-shot control bit limits the port to one frame for each frame-start write. Otherwise the port runs frame after frame, paced by line-start writes.

Top module: `readout_port`

## Requirements
- R1: After reset, `rd_data` is zero and `pix_ready` is low, and the port stays idle until a frame-start write arrives.
- R2: While `ctl_reg_out` is low, `pix_ready` stays low, every read returns zero, and frame-start and line-start writes have no effect.
- R3: A write with bit 31 set (frame start) empties the FIFO and begins a frame. `pix_ready` is high only while the port is running, the FIFO holds fewer than DEPTH pixels, fewer than `cfg_width*cfg_height` pixels have been taken in the current frame, and no frame-start write is being made.
- R4: With packed mode off, the read word is laid out as follows: bits 23:0 are the pixel (zero when none is delivered), bit 24 is valid, bit 25 is FIFO empty at the time of the read, bit 26 is end of line, and bits 31:27 are zero. The word appears on `rd_data` one cycle after `rd_en`.
- R5: A read with valid high removes the oldest pixel, so pixels come out in arrival order. A read with valid low removes nothing and changes no state.
- R6: After the last pixel of a line, the end-of-line flag is set. Until a write with bit 30 set (line start) clears it, reads deliver no pixel and show bit 26 high.
- R7: A line-start write made while the end-of-line flag is clear has no effect.
- R8: In one-shot mode, reading the last pixel of the last line returns the port to idle. Idle reads show only the empty flag, and no pixel is taken until the next frame-start write.
- R9: In continuous mode, reading the last pixel of the frame sets the end-of-line flag and opens intake for the next frame. The next line-start write resumes delivery at line 0.
- R10: In packed mode, a read with at least two pixels in the FIFO returns the older pixel as RGB565 `{R[7:3],G[7:2],B[7:3]}` in bits 15:0 and the next pixel in bits 31:16, and removes both. With fewer than two pixels, or when no pixel may be delivered, the read returns zero and removes nothing.
- R11: In packed mode, each delivering read advances the line position by two pixels, and the line ends after `cfg_width/2` reads. `cfg_width` must be even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_reg_out | input | 1 | Route pixels to the readout register |
| ctl_packed | input | 1 | Two RGB565 pixels per read, no status |
| ctl_oneshot | input | 1 | One frame per frame-start write |
| cfg_width | input | XW | Pixels per line |
| cfg_height | input | YW | Lines per frame |
| pix_valid | input | 1 | Compositor pixel present |
| pix_data | input | 24 | Compositor pixel, RGB888 |
| pix_ready | output | 1 | Port takes the pixel this cycle |
| rd_en | input | 1 | Readout register read strobe |
| rd_data | output | 32 | Read word, valid the cycle after `rd_en` |
| wr_en | input | 1 | Readout register write strobe |
| wr_data | input | 32 | Write data; bit 31 frame start, bit 30 line start |

## Verification
The bench targets line ends that arrive during a run of reads. A port that let the end-of-line flag leak would deliver the first pixel of the next line without a line-start write. The bench also sends stray line-start writes in mid-line, which a careless port would treat as a skip or a reset of the line position. A packed read with only one pixel in the FIFO must return zero; a wrong port would pop half a pair and shift every later pixel. The bench also checks one-shot frame ends, where intake must stop, and FIFO-full and frame-count limits on `pix_ready`, which a wrong port would overflow or overrun into the next frame.

// File: rtl/readout_pkg.sv
// readout_pkg: bit positions of the readout register and the pacing state type.
// Assumes: the 24-bit RGB888 pixel occupies the low bits of the read word.
package readout_pkg;
    localparam int PIX_W      = 24;
    localparam int WORD_W     = 32;
    localparam int VSTART_BIT = 31;
    localparam int HSTART_BIT = 30;
    localparam int EOL_BIT    = 26;
    localparam int EMPTY_BIT  = 25;
    localparam int VALID_BIT  = 24;

    typedef enum logic {
        PACE_IDLE = 1'b0,
        PACE_RUN  = 1'b1
    } pace_state_e;
endpackage

// File: rtl/readout_fifo.sv
// readout_fifo: small pixel FIFO that can pop one or two entries per cycle.
// Assumes: DEPTH is a power of two and at least 2; the caller never pushes when full
// and never pops more than count; flush has priority over push and pop.
module readout_fifo #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    input  logic                       pop_two,
    output logic [WIDTH-1:0]           head0,
    output logic [WIDTH-1:0]           head1,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr;
    logic [AW-1:0]    wr_ptr;
    logic [CW-1:0]    pop_cnt;

    // Number of entries leaving this cycle.
    always_comb begin
        pop_cnt = '0;
        if (pop) pop_cnt = pop_two ? CW'(2) : CW'(1);
    end

    // Storage write; entries need no reset.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            if (pop)  rd_ptr <= rd_ptr + AW'(pop_cnt);
            count <= count + CW'(push) - pop_cnt;
        end
    end

    // Two oldest entries and the full flag.
    always_comb begin
        head0 = mem[rd_ptr];
        head1 = mem[rd_ptr + AW'(1)];
        full  = (count == CW'(DEPTH));
    end
endmodule

// File: rtl/readout_pacer.sv
// readout_pacer: frame and line pacing driven by reader writes.
// Tracks the read-side line position, the end-of-line hold, one-shot stop and the
// per-frame intake limit. Assumes: cfg_width is nonzero (and even in packed mode),
// cfg_height is nonzero, and configuration is static while a frame runs.
module readout_pacer
    import readout_pkg::*;
#(
    parameter int XW = 12,
    parameter int YW = 12,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          oneshot,
    input  logic          packed_mode,
    input  logic [XW-1:0] cfg_width,
    input  logic [YW-1:0] cfg_height,
    input  logic          vstart,
    input  logic          hstart,
    input  logic [CW-1:0] fifo_count,
    input  logic          fifo_full,
    input  logic          push,
    input  logic          pop,
    output logic          running,
    output logic          eol,
    output logic          can_deliver,
    output logic          in_ready
);
    localparam int TW = XW + YW;

    pace_state_e   state;
    logic [XW-1:0] rd_x;
    logic [YW-1:0] rd_y;
    logic [TW-1:0] in_cnt;
    logic [TW-1:0] total;
    logic [XW:0]   step;
    logic [CW-1:0] need;
    logic          line_done;
    logic          frame_done;

    // Step size, line and frame end detection for the next delivering read.
    always_comb begin
        step        = packed_mode ? (XW+1)'(2) : (XW+1)'(1);
        need        = packed_mode ? CW'(2) : CW'(1);
        line_done   = (({1'b0, rd_x} + step) == {1'b0, cfg_width});
        frame_done  = line_done && (rd_y == cfg_height - YW'(1));
        total       = TW'(cfg_width) * TW'(cfg_height);
        running     = (state == PACE_RUN);
        can_deliver = running && !eol && (fifo_count >= need);
        in_ready    = enable && running && (in_cnt < total) && !fifo_full && !vstart;
    end

    // Read-side position, end-of-line hold and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PACE_IDLE;
            eol   <= 1'b0;
            rd_x  <= '0;
            rd_y  <= '0;
        end else if (vstart) begin
            state <= PACE_RUN;
            eol   <= 1'b0;
            rd_x  <= '0;
            rd_y  <= '0;
        end else if (pop) begin
            if (line_done) begin
                rd_x <= '0;
                if (frame_done) begin
                    rd_y <= '0;
                    if (oneshot) begin
                        state <= PACE_IDLE;
                        eol   <= 1'b0;
                    end else begin
                        eol <= 1'b1;
                    end
                end else begin
                    rd_y <= rd_y + YW'(1);
                    eol  <= 1'b1;
                end
            end else begin
                rd_x <= rd_x + step[XW-1:0];
            end
        end else if (hstart && running && eol) begin
            eol <= 1'b0;
        end
    end

    // Pixels taken from the compositor in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || vstart) begin
            in_cnt <= '0;
        end else if (pop && frame_done) begin
            in_cnt <= '0;
        end else if (push) begin
            in_cnt <= in_cnt + TW'(1);
        end
    end
endmodule

// File: rtl/readout_formatter.sv
// readout_formatter: builds the read word from the FIFO head and pacing flags.
// Assumes: head1 is meaningful only when the FIFO holds two entries and deliver is set.
module readout_formatter
    import readout_pkg::*;
(
    input  logic              packed_mode,
    input  logic              deliver,
    input  logic              eol,
    input  logic              empty,
    input  logic [PIX_W-1:0]  head0,
    input  logic [PIX_W-1:0]  head1,
    output logic [WORD_W-1:0] word
);
    logic [15:0] lo565;
    logic [15:0] hi565;
    logic        h1_unused_bits;

    // RGB888 to RGB565 reduction of the two oldest pixels.
    always_comb begin
        lo565 = {head0[23:19], head0[15:10], head0[7:3]};
        hi565 = {head1[23:19], head1[15:10], head1[7:3]};
        h1_unused_bits = ^{head1[18:16], head1[9:8], head1[2:0]};
    end

    // Word layout selection.
    always_comb begin
        word = '0;
        if (packed_mode) begin
            if (deliver) word = {hi565, lo565};
        end else begin
            if (deliver) word[PIX_W-1:0] = head0;
            word[VALID_BIT] = deliver;
            word[EMPTY_BIT] = empty;
            word[EOL_BIT]   = eol;
        end
    end
endmodule

// File: rtl/readout_port.sv
// readout_port: register readout path for composed pixels.
// Pixels enter a FIFO from the compositor. The reader polls one register for words
// and writes the same register to start frames (bit 31) and lines (bit 30).
// Assumes: reads and writes are not made in the same cycle; control is static per frame.
module readout_port
    import readout_pkg::*;
#(
    parameter int XW    = 12,
    parameter int YW    = 12,
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_reg_out,
    input  logic              ctl_packed,
    input  logic              ctl_oneshot,
    input  logic [XW-1:0]     cfg_width,
    input  logic [YW-1:0]     cfg_height,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    output logic              pix_ready,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data
);
    localparam int CW = $clog2(DEPTH+1);

    logic              vstart;
    logic              hstart;
    logic              push;
    logic              pop;
    logic              running;
    logic              eol_flag;
    logic              can_deliver;
    logic              fifo_full;
    logic [CW-1:0]     fifo_count;
    logic [PIX_W-1:0]  head0;
    logic [PIX_W-1:0]  head1;
    logic [WORD_W-1:0] word;
    logic              wr_unused_bits;

    // Decode of reader writes and reads, and the compositor handshake.
    always_comb begin
        vstart         = ctl_reg_out && wr_en && wr_data[VSTART_BIT];
        hstart         = ctl_reg_out && wr_en && wr_data[HSTART_BIT];
        pop            = ctl_reg_out && rd_en && can_deliver;
        push           = pix_valid && pix_ready;
        wr_unused_bits = ^wr_data[HSTART_BIT-1:0];
    end

    readout_fifo #(.WIDTH(PIX_W), .DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (vstart),
        .push      (push),
        .push_data (pix_data),
        .pop       (pop),
        .pop_two   (ctl_packed),
        .head0     (head0),
        .head1     (head1),
        .count     (fifo_count),
        .full      (fifo_full)
    );

    readout_pacer #(.XW(XW), .YW(YW), .CW(CW)) pacer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (ctl_reg_out),
        .oneshot     (ctl_oneshot),
        .packed_mode (ctl_packed),
        .cfg_width   (cfg_width),
        .cfg_height  (cfg_height),
        .vstart      (vstart),
        .hstart      (hstart),
        .fifo_count  (fifo_count),
        .fifo_full   (fifo_full),
        .push        (push),
        .pop         (pop),
        .running     (running),
        .eol         (eol_flag),
        .can_deliver (can_deliver),
        .in_ready    (pix_ready)
    );

    readout_formatter fmt_i (
        .packed_mode (ctl_packed),
        .deliver     (pop),
        .eol         (eol_flag),
        .empty       (fifo_count == '0),
        .head0       (head0),
        .head1       (head1),
        .word        (word)
    );

    // Read word register, loaded on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= ctl_reg_out ? word : '0;
        end
    end
endmodule

// File: rtl/readout_port_chk.sv
// readout_port_chk: temporal checks on the readout port, bound into every instance.
// Assumes: the bound instance exposes its pacing and FIFO signals by the names below.
module readout_port_chk #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ctl_reg_out,
    input logic                       ctl_packed,
    input logic                       pix_valid,
    input logic                       pix_ready,
    input logic                       rd_en,
    input logic [1:0]                 rd_status,
    input logic                       wr_en,
    input logic                       running,
    input logic                       eol_flag,
    input logic                       pop,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count
);
    a_r3_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= ($clog2(DEPTH+1))'(DEPTH));

    a_r2_no_accept_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready) |-> ctl_reg_out);

    a_r8_idle_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !pix_ready);

    a_r6_no_pop_at_eol: assert property (@(posedge clk) disable iff (!rst_n)
        eol_flag |-> !pop);

    a_r6_eol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (eol_flag && !wr_en) |=> eol_flag);

    a_r4_valid_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ctl_reg_out && !ctl_packed) |=> !(rd_status == 2'b11));

    a_r5_idle_read_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !running) |-> !pop);
endmodule

bind readout_port readout_port_chk #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_reg_out (ctl_reg_out),
    .ctl_packed  (ctl_packed),
    .pix_valid   (pix_valid),
    .pix_ready   (pix_ready),
    .rd_en       (rd_en),
    .rd_status   (rd_data[25:24]),
    .wr_en       (wr_en),
    .running     (running),
    .eol_flag    (eol_flag),
    .pop         (pop),
    .fifo_count  (fifo_count)
);

// File: tb/readout_port_tb_top.sv
// Bench for readout_port: a reference model of pacing and the FIFO, driven by seeded
// random traffic and directed corner cases.
module readout_port_tb_top;
    localparam int XW = 12;
    localparam int YW = 12;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          ctl_reg_out, ctl_packed, ctl_oneshot;
    logic [XW-1:0] cfg_width;
    logic [YW-1:0] cfg_height;
    logic          pix_valid;
    logic [23:0]   pix_data;
    logic          pix_ready;
    logic          rd_en;
    logic [31:0]   rd_data;
    logic          wr_en;
    logic [31:0]   wr_data;

    readout_port #(.XW(XW), .YW(YW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_reg_out(ctl_reg_out), .ctl_packed(ctl_packed),
        .ctl_oneshot(ctl_oneshot), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .rd_en(rd_en), .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    bit m_run, m_eol;
    int m_x, m_y, m_in, m_frames;
    logic [23:0] q[$];
    logic [31:0] last_exp;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] to565(logic [23:0] p);
        return {p[23:19], p[15:10], p[7:3]};
    endfunction

    function automatic int need_n();
        return ctl_packed ? 2 : 1;
    endfunction

    function automatic bit model_deliver();
        return ctl_reg_out && m_run && !m_eol && (q.size() >= need_n());
    endfunction

    function automatic logic [31:0] exp_read();
        bit d = model_deliver();
        if (!ctl_reg_out) return 32'h0;
        if (ctl_packed) return d ? {to565(q[1]), to565(q[0])} : 32'h0;
        return {5'b0, m_eol, (q.size() == 0), d, (d ? q[0] : 24'h0)};
    endfunction

    task automatic model_pop();
        int n = need_n();
        repeat (n) void'(q.pop_front());
        m_x += n;
        if (m_x == int'(cfg_width)) begin
            m_x = 0;
            if (m_y == int'(cfg_height) - 1) begin
                m_in = 0;
                m_frames++;
                m_y = 0;
                if (ctl_oneshot) begin m_run = 0; m_eol = 0; end
                else m_eol = 1;
            end else begin
                m_y++;
                m_eol = 1;
            end
        end
    endtask

    task automatic cycle(bit rd, bit wr, logic [31:0] wd, bit pv, logic [23:0] pd);
        logic [31:0] ew;
        bit acc, er, vst, dlv;
        string tg, rtg;
        ew = 32'h0; dlv = 0; rtg = "R4";
        @(negedge clk);
        rd_en = rd; wr_en = wr; wr_data = wd; pix_valid = pv; pix_data = pd;
        #1;
        vst = wr && wd[31] && ctl_reg_out;
        er = ctl_reg_out && m_run && (m_in < int'(cfg_width) * int'(cfg_height))
             && (q.size() < DEPTH) && !vst;
        if (!ctl_reg_out) tg = "R2";
        else if (!m_run) tg = "R8";
        else if (m_frames > 0 && !ctl_oneshot) tg = "R9";
        else tg = "R3";
        check(tg, {31'b0, pix_ready}, {31'b0, er}, "pix_ready");
        acc = pv && pix_ready;
        if (rd) begin
            ew = exp_read();
            dlv = model_deliver();
            if (!ctl_reg_out) rtg = "R2";
            else if (ctl_packed) rtg = m_eol ? "R11" : "R10";
            else if (!m_run) rtg = "R8";
            else if (m_eol) rtg = "R6";
            else rtg = dlv ? "R4" : "R5";
        end
        @(posedge clk);
        #1;
        if (rd) begin
            check(rtg, rd_data, ew, "read word");
            last_exp = ew;
            if (dlv) model_pop();
        end
        if (wr && ctl_reg_out) begin
            if (wd[31]) begin
                m_run = 1; m_eol = 0; m_x = 0; m_y = 0; m_in = 0; q.delete();
            end else if (wd[30] && m_run && m_eol) begin
                m_eol = 0;
            end
        end
        if (acc) begin
            q.push_back(pd);
            m_in++;
        end
        rd_en = 0; wr_en = 0; pix_valid = 0;
    endtask

    task automatic set_cfg(bit ro, bit pk, bit os, int w, int h);
        @(negedge clk);
        ctl_reg_out = ro; ctl_packed = pk; ctl_oneshot = os;
        cfg_width = XW'(w); cfg_height = YW'(h);
        m_frames = 0;
    endtask

    task automatic run_rand(int ncyc, int rd_pct, bit stop_idle);
        for (int i = 0; i < ncyc; i++) begin
            int r;
            if (stop_idle && !m_run) break;
            r = $urandom % 100;
            if (m_eol && r < 30) cycle(0, 1, 32'h4000_0000, 0, 24'h0);
            else if (!m_eol && m_run && r < 4) cycle(0, 1, 32'h4000_0000, 0, 24'h0);
            else cycle(($urandom % 100) < rd_pct, 0, 32'h0, ($urandom % 100) < 70,
                       24'($urandom));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; ctl_reg_out = 0; ctl_packed = 0; ctl_oneshot = 0;
        cfg_width = XW'(4); cfg_height = YW'(3);
        pix_valid = 0; pix_data = 0; rd_en = 0; wr_en = 0; wr_data = 0;
        m_run = 0; m_eol = 0; m_x = 0; m_y = 0; m_in = 0; m_frames = 0;
        last_exp = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        ctl_reg_out = 1;
        #1;
        check("R1", rd_data, 32'h0, "reset rd_data");
        check("R1", {31'b0, pix_ready}, 32'h0, "reset pix_ready");

        // R2: port disabled, writes and pixels ignored
        set_cfg(0, 0, 0, 4, 3);
        cycle(0, 1, 32'h8000_0000, 0, 24'h0);
        cycle(0, 0, 32'h0, 1, 24'h123456);
        cycle(1, 0, 32'h0, 0, 24'h0);
        check("R2", rd_data, 32'h0, "disabled read");

        // R8: enabled but idle read shows only empty
        set_cfg(1, 0, 0, 4, 3);
        cycle(1, 0, 32'h0, 1, 24'hABCDEF);
        check("R8", rd_data, 32'h0200_0000, "idle read");

        // Continuous unpacked, with a directed R7 stray line start
        cycle(0, 1, 32'h8000_0000, 0, 24'h0);
        cycle(0, 0, 32'h0, 1, 24'h112233);
        cycle(0, 0, 32'h0, 1, 24'h445566);
        cycle(0, 1, 32'h4000_0000, 0, 24'h0);
        cycle(1, 0, 32'h0, 0, 24'h0);
        check("R7", rd_data, 32'h0111_2233, "read after stray line start");
        run_rand(400, 50, 0);

        // One-shot frame, then idle intake and a restart
        set_cfg(1, 0, 1, 3, 2);
        cycle(0, 1, 32'h8000_0000, 0, 24'h0);
        run_rand(400, 50, 1);
        check("R8", {31'b0, m_run}, 32'h0, "one-shot frame ended");
        repeat (4) cycle(0, 0, 32'h0, 1, 24'h0F0F0F);
        cycle(1, 0, 32'h0, 0, 24'h0);
        check("R8", rd_data, 32'h0200_0000, "read after one-shot end");
        cycle(0, 1, 32'h8000_0000, 0, 24'h0);
        run_rand(300, 50, 1);

        // Packed mode: a lone pixel must not be delivered
        set_cfg(1, 1, 0, 4, 2);
        cycle(0, 1, 32'h8000_0000, 0, 24'h0);
        cycle(0, 0, 32'h0, 1, 24'hF8FC00);
        cycle(1, 0, 32'h0, 0, 24'h0);
        check("R10", rd_data, 32'h0, "packed read with one pixel");
        cycle(0, 0, 32'h0, 1, 24'h0000F8);
        cycle(1, 0, 32'h0, 0, 24'h0);
        check("R10", rd_data, {16'h001F, 16'hFFE0}, "packed pair");
        run_rand(400, 50, 0);

        // Long line with slow reader to reach a full FIFO
        set_cfg(1, 0, 0, 20, 2);
        cycle(0, 1, 32'h8000_0000, 0, 24'h0);
        run_rand(400, 10, 0);
        run_rand(300, 60, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule